// File: doc/BRIEF.md
# Expander Register Access Controller

This block sits behind a byte-oriented serial bus slave and serves the register side of a 40-line I/O expander. The slave reports a small set of events: a transaction start (first or repeated), a write byte that has passed the address match, a request for a read byte, the acknowledge of the current byte, and a stop. The first byte written after a start is a command. Its bit 7 turns on auto-increment, bit 6 is ignored, and bits 5:0 select a register. Every later byte is written to, or read from, the register that the pointer selects.

The registers are organised in five categories, each holding five 8-bit banks. Address bits 5:3 select the category and bits 2:0 select the bank. The categories and their bank-0 addresses are input 0x00, output 0x08, polarity inversion 0x10, configuration 0x18 and interrupt mask 0x20. Three single control registers follow: output structure at 0x28, all-bank control at 0x29 and mode selection at 0x2A. The controller is a six-state machine:

- IDLE waits for a start.
- CMD waits for the command byte or a read request.
- CMD_ACK holds the command until its acknowledge.
- DATA waits for the next data byte or read request.
- WACK holds a written byte until its acknowledge.
- RACK holds a read byte until its acknowledge.

A start from any state moves to CMD. A stop from any state moves to IDLE, and stop wins when both arrive in the same cycle. In CMD, a write byte moves to CMD_ACK and a read request moves to RACK. An acknowledge moves CMD_ACK, WACK and RACK back to DATA. In DATA, a write byte moves to WACK and a read request moves to RACK.

Top module: `exp_reg_ctrl`

## Requirements
- R1: After reset the pointer is 0x00, auto-increment is off, every register output is 0x00 and rd_data is 0x00.
- R2: A command takes effect on its acknowledge. Bits 5:0 become the pointer and bit 7 becomes the auto-increment flag. Bit 6 has no effect.
- R3: With auto-increment off, every data byte in the transaction uses the same register, so repeated writes leave only the last value.
- R4: With auto-increment on and the pointer in a banked category (address bits 5:3 below 5), each byte acknowledge moves the pointer to the next bank. From bank 4 (or banks 5 to 7) it returns to bank 0 of the same category.
- R5: The control registers are at 0x28, 0x29 and 0x2A. With the pointer in the control group, the pointer never advances, so each extra byte overwrites the previous value.
- R6: A written byte changes its register only on that byte's acknowledge. Between the write byte and its acknowledge, the register output keeps its old value.
- R7: A read of input bank k returns pin byte k XOR polarity bank k. Pin byte k is pins[8k+7:8k].
- R8: Banks 5 to 7 of any category, addresses 0x2B to 0x3F and writes to input banks have no effect on writes. The unmapped addresses read as 0x00.
- R9: A repeated start keeps the pointer. A read request that directly follows a start returns the register that the last command selected.
- R10: After a stop, write bytes and acknowledges are ignored until the next start.
- R11: rd_data takes the value of the selected register in the cycle after the read request and holds it until the next read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_start | input | 1 | Start or repeated start event (one cycle) |
| bus_wbyte | input | 1 | Address-matched write byte present on bus_wdata |
| bus_wdata | input | 8 | Written byte |
| bus_rreq | input | 1 | Request for the next read byte |
| bus_ack | input | 1 | Current byte acknowledged |
| bus_stop | input | 1 | Stop event |
| pins | input | 40 | Input pin states, bank k in bits 8k+7:8k |
| rd_data | output | 8 | Byte returned for the last read request |
| out_vec | output | 40 | Output banks |
| pol_vec | output | 40 | Polarity inversion banks |
| cfg_vec | output | 40 | Configuration banks |
| msk_vec | output | 40 | Interrupt mask banks |
| ctl_ostruct | output | 8 | Output structure control register |
| ctl_allbank | output | 8 | All-bank control register |
| ctl_mode | output | 8 | Mode selection register |

## Verification
The hardest case to reach from the ports is the wrap of the pointer in the middle of a transaction. It only shows up when the sixth byte of one auto-increment sequence lands in bank 0 rather than in a neighbouring category. The bench reaches it by writing six bytes in a single transaction that starts at configuration bank 0. It then reads six bytes back after a repeated start. The bank-0 value must appear at both ends of the read sequence, and the interrupt mask category must stay untouched.

// File: rtl/exp_pkg.sv
package exp_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_CMD,
        S_CMD_ACK,
        S_DATA,
        S_WACK,
        S_RACK
    } state_t;

    localparam int CAT_IN  = 0;
    localparam int CAT_OUT = 1;
    localparam int CAT_POL = 2;
    localparam int CAT_CFG = 3;
    localparam int CAT_MSK = 4;
    localparam int CAT_CTL = 5;
endpackage

// File: rtl/exp_ptr_next.sv
module exp_ptr_next #(
    parameter int NBANK = 5
) (
    input  logic [5:0] ptr,
    input  logic       ai,
    output logic [5:0] nxt
);
    import exp_pkg::*;

    always_comb begin
        nxt = ptr;
        if (ai && (ptr[5:3] < 3'(CAT_CTL))) begin
            if (ptr[2:0] >= 3'(NBANK - 1)) begin
                nxt = {ptr[5:3], 3'b000};
            end else begin
                nxt = ptr + 6'd1;
            end
        end
    end
endmodule

// File: rtl/exp_reg_file.sv
module exp_reg_file #(
    parameter int NBANK = 5,
    parameter int DW    = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [5:0]         waddr,
    input  logic [DW-1:0]      wdata,
    input  logic [5:0]         raddr,
    input  logic [NBANK*DW-1:0] pins,
    output logic [DW-1:0]      rdata,
    output logic [NBANK*DW-1:0] out_vec,
    output logic [NBANK*DW-1:0] pol_vec,
    output logic [NBANK*DW-1:0] cfg_vec,
    output logic [NBANK*DW-1:0] msk_vec,
    output logic [DW-1:0]      ctl0,
    output logic [DW-1:0]      ctl1,
    output logic [DW-1:0]      ctl2
);
    import exp_pkg::*;

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic [DW-1:0] oq, pq, cq, mq;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                oq <= '0;
                pq <= '0;
                cq <= '0;
                mq <= '0;
            end else if (we && waddr[2:0] == 3'(b)) begin
                if (waddr[5:3] == 3'(CAT_OUT)) oq <= wdata;
                if (waddr[5:3] == 3'(CAT_POL)) pq <= wdata;
                if (waddr[5:3] == 3'(CAT_CFG)) cq <= wdata;
                if (waddr[5:3] == 3'(CAT_MSK)) mq <= wdata;
            end
        end
        assign out_vec[b*DW +: DW] = oq;
        assign pol_vec[b*DW +: DW] = pq;
        assign cfg_vec[b*DW +: DW] = cq;
        assign msk_vec[b*DW +: DW] = mq;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl0 <= '0;
            ctl1 <= '0;
            ctl2 <= '0;
        end else if (we && waddr[5:3] == 3'(CAT_CTL)) begin
            if (waddr[2:0] == 3'd0) ctl0 <= wdata;
            if (waddr[2:0] == 3'd1) ctl1 <= wdata;
            if (waddr[2:0] == 3'd2) ctl2 <= wdata;
        end
    end

    always_comb begin
        int bi;
        bi    = int'(raddr[2:0]);
        rdata = '0;
        if (raddr[5:3] == 3'(CAT_CTL)) begin
            case (raddr[2:0])
                3'd0:    rdata = ctl0;
                3'd1:    rdata = ctl1;
                3'd2:    rdata = ctl2;
                default: rdata = '0;
            endcase
        end else if (bi < NBANK) begin
            case (int'(raddr[5:3]))
                CAT_IN:  rdata = pins[bi*DW +: DW] ^ pol_vec[bi*DW +: DW];
                CAT_OUT: rdata = out_vec[bi*DW +: DW];
                CAT_POL: rdata = pol_vec[bi*DW +: DW];
                CAT_CFG: rdata = cfg_vec[bi*DW +: DW];
                CAT_MSK: rdata = msk_vec[bi*DW +: DW];
                default: rdata = '0;
            endcase
        end
    end

    // Register contents move only on a cycle with a write enable
    assert_hold_without_we_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> ($stable(out_vec) && $stable(pol_vec) && $stable(cfg_vec) &&
                 $stable(msk_vec) && $stable(ctl0) && $stable(ctl1) && $stable(ctl2)));

    // A write to the input category or an unmapped address changes nothing
    assert_unmapped_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (we && (waddr[5:3] == 3'(CAT_IN) || waddr[5:3] > 3'(CAT_CTL) ||
                (waddr[5:3] == 3'(CAT_CTL) && waddr[2:0] > 3'd2) ||
                (waddr[5:3] != 3'(CAT_CTL) && waddr[2:0] >= 3'(NBANK))))
        |=> ($stable(out_vec) && $stable(pol_vec) && $stable(cfg_vec) &&
             $stable(msk_vec) && $stable(ctl0) && $stable(ctl1) && $stable(ctl2)));
endmodule

// File: rtl/exp_reg_ctrl.sv
module exp_reg_ctrl #(
    parameter int NBANK = 5,
    parameter int DW    = 8,
    localparam int W    = NBANK * DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_start,
    input  logic          bus_wbyte,
    input  logic [DW-1:0] bus_wdata,
    input  logic          bus_rreq,
    input  logic          bus_ack,
    input  logic          bus_stop,
    input  logic [W-1:0]  pins,
    output logic [DW-1:0] rd_data,
    output logic [W-1:0]  out_vec,
    output logic [W-1:0]  pol_vec,
    output logic [W-1:0]  cfg_vec,
    output logic [W-1:0]  msk_vec,
    output logic [DW-1:0] ctl_ostruct,
    output logic [DW-1:0] ctl_allbank,
    output logic [DW-1:0] ctl_mode
);
    import exp_pkg::*;

    state_t        st, st_nxt;
    logic [5:0]    ptr, ptr_adv;
    logic          ai;
    logic [DW-1:0] hold;
    logic [DW-1:0] rf_rdata;
    logic          accept, we;

    assign accept = !bus_start && !bus_stop;
    assign we     = accept && bus_ack && (st == S_WACK);

    exp_ptr_next #(.NBANK(NBANK)) u_next (
        .ptr (ptr),
        .ai  (ai),
        .nxt (ptr_adv)
    );

    exp_reg_file #(.NBANK(NBANK), .DW(DW)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (we),
        .waddr   (ptr),
        .wdata   (hold),
        .raddr   (ptr),
        .pins    (pins),
        .rdata   (rf_rdata),
        .out_vec (out_vec),
        .pol_vec (pol_vec),
        .cfg_vec (cfg_vec),
        .msk_vec (msk_vec),
        .ctl0    (ctl_ostruct),
        .ctl1    (ctl_allbank),
        .ctl2    (ctl_mode)
    );

    always_comb begin
        st_nxt = st;
        if (bus_stop) begin
            st_nxt = S_IDLE;
        end else if (bus_start) begin
            st_nxt = S_CMD;
        end else begin
            unique case (st)
                S_IDLE:    st_nxt = S_IDLE;
                S_CMD:     if (bus_wbyte) st_nxt = S_CMD_ACK;
                           else if (bus_rreq) st_nxt = S_RACK;
                S_CMD_ACK: if (bus_ack) st_nxt = S_DATA;
                S_DATA:    if (bus_wbyte) st_nxt = S_WACK;
                           else if (bus_rreq) st_nxt = S_RACK;
                S_WACK:    if (bus_ack) st_nxt = S_DATA;
                S_RACK:    if (bus_ack) st_nxt = S_DATA;
                default:   st_nxt = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr     <= '0;
            ai      <= 1'b0;
            hold    <= '0;
            rd_data <= '0;
        end else if (accept) begin
            if (bus_wbyte && (st == S_CMD || st == S_DATA)) hold <= bus_wdata;
            if (bus_rreq && (st == S_CMD || st == S_DATA)) rd_data <= rf_rdata;
            if (bus_ack && st == S_CMD_ACK) begin
                ptr <= hold[5:0];
                ai  <= hold[7];
            end else if (bus_ack && (st == S_WACK || st == S_RACK)) begin
                ptr <= ptr_adv;
            end
        end
    end

    // Command acknowledge loads pointer and increment flag from the held byte
    assert_cmd_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_CMD_ACK && bus_ack && accept)
        |=> (ptr == $past(hold[5:0]) && ai == $past(hold[7]) && st == S_DATA));

    // Without auto-increment the pointer never moves on a data byte
    assert_fixed_ptr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == S_WACK || st == S_RACK) && !ai && accept) |=> $stable(ptr));

    // The last bank of a category returns to bank 0 of the same category
    assert_wrap_in_cat_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == S_WACK || st == S_RACK) && bus_ack && accept && ai &&
         ptr[5:3] < 3'(CAT_CTL) && ptr[2:0] == 3'(NBANK - 1))
        |=> (ptr[2:0] == 3'd0 && $stable(ptr[5:3])));

    // Control group pointer is never advanced
    assert_ctl_fixed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == S_WACK || st == S_RACK) && ptr[5:3] == 3'(CAT_CTL) && accept)
        |=> $stable(ptr));

    // A repeated start keeps the pointer and awaits a command or read
    assert_start_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_start && !bus_stop) |=> ($stable(ptr) && st == S_CMD));

    // Stop always returns to idle
    assert_stop_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_stop |=> st == S_IDLE);

    // Write enable only while idle is impossible
    assert_idle_no_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_IDLE) |-> !we);
endmodule

// File: tb/tb_exp_reg_ctrl.sv
`timescale 1ns/1ps
module tb_exp_reg_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_start = 1'b0, bus_wbyte = 1'b0, bus_rreq = 1'b0;
    logic        bus_ack = 1'b0, bus_stop = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [39:0] pins = '0;
    logic [7:0]  rd_data, ctl_ostruct, ctl_allbank, ctl_mode;
    logic [39:0] out_vec, pol_vec, cfg_vec, msk_vec;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    exp_reg_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_wbyte(bus_wbyte),
        .bus_wdata(bus_wdata), .bus_rreq(bus_rreq), .bus_ack(bus_ack),
        .bus_stop(bus_stop), .pins(pins), .rd_data(rd_data), .out_vec(out_vec),
        .pol_vec(pol_vec), .cfg_vec(cfg_vec), .msk_vec(msk_vec),
        .ctl_ostruct(ctl_ostruct), .ctl_allbank(ctl_allbank), .ctl_mode(ctl_mode)
    );

    // {address, written byte, expected read back}; AI off
    localparam logic [23:0] VEC [10] = '{
        {8'h08, 8'hA5, 8'hA5},
        {8'h0C, 8'h3C, 8'h3C},
        {8'h12, 8'h81, 8'h81},
        {8'h1B, 8'h0F, 8'h0F},
        {8'h24, 8'hF0, 8'hF0},
        {8'h28, 8'h55, 8'h55},
        {8'h2A, 8'hC3, 8'hC3},
        {8'h0D, 8'h77, 8'h00},
        {8'h2B, 8'h99, 8'h00},
        {8'h02, 8'hFF, 8'h81}
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_start();
        @(negedge clk) bus_start = 1'b1;
        @(negedge clk) bus_start = 1'b0;
    endtask

    task automatic do_stop();
        @(negedge clk) bus_stop = 1'b1;
        @(negedge clk) bus_stop = 1'b0;
    endtask

    task automatic do_wbyte(input logic [7:0] b);
        @(negedge clk) begin bus_wbyte = 1'b1; bus_wdata = b; end
        @(negedge clk) bus_wbyte = 1'b0;
    endtask

    task automatic do_ack();
        @(negedge clk) bus_ack = 1'b1;
        @(negedge clk) bus_ack = 1'b0;
    endtask

    task automatic send(input logic [7:0] b);
        do_wbyte(b);
        do_ack();
    endtask

    task automatic fetch(output logic [7:0] v);
        @(negedge clk) bus_rreq = 1'b1;
        @(negedge clk) begin bus_rreq = 1'b0; v = rd_data; end
        do_ack();
    endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic [7:0] exp_in;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 rd_data", {56'd0, rd_data}, 64'd0);
        chk("R1 registers", {24'd0, out_vec} | {24'd0, pol_vec} | {24'd0, cfg_vec} |
            {24'd0, msk_vec} | {40'd0, ctl_ostruct, ctl_allbank, ctl_mode}, 64'd0);
        do_start();
        fetch(v);
        do_stop();
        chk("R1 pointer 0 reads input bank 0", {56'd0, v}, 64'd0);

        // Table: write with AI off, repeated start, read back (R2 R8 R9 R11)
        for (int i = 0; i < 10; i++) begin
            do_start();
            send(VEC[i][23:16]);
            send(VEC[i][15:8]);
            do_start();
            fetch(v);
            do_stop();
            chk($sformatf("R9 R11 R8 vector %0d", i), {56'd0, v}, {56'd0, VEC[i][7:0]});
        end

        // R6: value appears only on acknowledge
        do_start();
        send(8'h09);
        do_wbyte(8'h6E);
        chk("R6 before ack", {56'd0, out_vec[15:8]}, 64'd0);
        do_ack();
        chk("R6 after ack", {56'd0, out_vec[15:8]}, 64'h6E);
        do_stop();

        // R3: AI off, three writes to one register
        do_start();
        send(8'h0C);
        send(8'h01); send(8'h02); send(8'h03);
        do_stop();
        chk("R3 last value kept", {24'd0, out_vec}, {24'd0, 8'h03, 8'h00, 8'h00, 8'h6E, 8'hA5});

        // R4: AI write of six bytes from configuration bank 0 wraps inside the category
        do_start();
        send(8'h98);
        send(8'h11); send(8'h22); send(8'h33); send(8'h44); send(8'h55); send(8'h66);
        do_stop();
        chk("R4 cfg wrap write", {24'd0, cfg_vec}, {24'd0, 8'h55, 8'h44, 8'h33, 8'h22, 8'h66});
        chk("R4 mask untouched", {24'd0, msk_vec}, {24'd0, 8'hF0, 32'd0});
        do_start();
        send(8'h98);
        do_start();
        for (int k = 0; k < 6; k++) begin
            fetch(v);
            if (k == 0 || k == 5) chk($sformatf("R4 wrap read %0d", k), {56'd0, v}, 64'h66);
        end
        do_stop();

        // R5: control with AI overwrites in place
        do_start();
        send(8'hA9);
        send(8'h10); send(8'h20);
        do_stop();
        chk("R5 allbank overwritten", {56'd0, ctl_allbank}, 64'h20);
        chk("R5 neighbours kept", {48'd0, ctl_ostruct, ctl_mode}, {48'd0, 8'h55, 8'hC3});

        // R2: bit 6 ignored
        do_start();
        send(8'h48);
        send(8'h5A);
        do_stop();
        chk("R2 bit6 ignored", {56'd0, out_vec[7:0]}, 64'h5A);

        // R7: input read XOR polarity (polarity bank 2 = 0x81)
        pins = 40'h12_34_56_78_9A;
        do_start();
        send(8'h80);
        do_start();
        for (int k = 0; k < 5; k++) begin
            fetch(v);
            exp_in = pins[k*8 +: 8] ^ ((k == 2) ? 8'h81 : 8'h00);
            chk($sformatf("R7 input bank %0d", k), {56'd0, v}, {56'd0, exp_in});
        end
        do_stop();

        // R10: bytes after stop are ignored
        do_wbyte(8'h08);
        do_ack();
        do_wbyte(8'hEE);
        do_ack();
        chk("R10 ignored after stop", {56'd0, out_vec[7:0]}, 64'h5A);

        // R11: rd_data holds until next read request
        chk("R11 rd_data held", {56'd0, rd_data}, 64'h12);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule